// File: doc/BRIEF.md
# Multi-source controller reset generator

This block drives the active-low hardware reset of a peripheral bus controller. Three things can request that reset: the host's active-high system reset, a software write to a dedicated reset port, and a raw front-panel push button. All three requests are merged into one clean output. That output is forced low at once, but it returns high only on a system clock edge, and never before a minimum low time has passed.

The core is a three-state machine: `RS_IDLE` (output high), `RS_HOLD` (a level source is active) and `RS_STRETCH` (a countdown of `PULSE_CYCLES` clocks is running). It moves between them as follows:
- `RS_IDLE`→`RS_HOLD` when a level request appears.
- `RS_IDLE`→`RS_STRETCH` on a software trigger.
- `RS_HOLD`→`RS_STRETCH` when the level request ends.
- `RS_STRETCH`→`RS_STRETCH` when a new software trigger reloads the count.
- `RS_STRETCH`→`RS_HOLD` when a level request appears.
- `RS_STRETCH`→`RS_IDLE` when the count expires.

The system reset acts as the asynchronous reset of the machine and puts it in `RS_HOLD`. The button is synchronised and debounced, and its filtered level is the level request.

Top module: `ctl_reset_gen`

## Requirements
- R1: `ctl_rst_n` is low while a reset is in progress and high otherwise. `rst_busy` is always its inverse. While `sys_reset` is held, the output is low and the busy flag is high.
- R2: A high `sys_reset` drives `ctl_rst_n` low immediately, without waiting for a clock. After `sys_reset` falls, the output stays low for exactly `PULSE_CYCLES` more rising clock edges.
- R3: A software trigger is a clock edge at which `io_wr_n` is sampled low after being high at the previous edge, while `card_sel` is 1 and `port_ofs` equals 2'b11. It makes `ctl_rst_n` low from that edge for exactly `PULSE_CYCLES` edges. A write with `card_sel` at 0, or to offsets 2'b00, 2'b01 or 2'b10, has no effect. No data value takes part.
- R4: Each low period of `ctl_rst_n` lasts at least `PULSE_CYCLES` clock cycles.
- R5: The raw button `btn_n` (low = pressed) passes through a 2-flop synchroniser. The filtered level changes only after `DEB_CYCLES` consecutive synchronised samples differ from it. A press shorter than that leaves the output high.
- R6: While the filtered button is pressed, `ctl_rst_n` stays low. After the filtered release, it stays low for `PULSE_CYCLES` more edges.
- R7: A software trigger during a running countdown restarts the count at full length.
- R8: A write strobe held low for several cycles produces exactly one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_reset | input | 1 | Host system reset, active high, asynchronous assert |
| card_sel | input | 1 | Base-address match from the card decoder, active high |
| port_ofs | input | 2 | Port offset within the card window |
| io_wr_n | input | 1 | I/O write strobe, active low, synchronous to clk |
| btn_n | input | 1 | Raw push button, active low, asynchronous and bouncing |
| ctl_rst_n | output | 1 | Reset to the controller, active low |
| rst_busy | output | 1 | High while a reset is in progress |

## Verification
The bench builds the block with `PULSE_CYCLES` = 6 and `DEB_CYCLES` = 5. These short values let a few hundred cycles cover the countdown expiry, a restart in mid-count, filtered presses, rejected short presses and a bouncing button. They also make stretch windows that overlap a button hold easy to reach. An asynchronous mid-cycle system reset is included so that the immediate drop of the output can be seen between clock edges.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_HOLD    = 2'd1,
        RS_STRETCH = 2'd2
    } rs_state_e;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int  STAGES  = 2,
    parameter bit  RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) chain[0] <= RST_VAL;
        else      chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or posedge arst) begin
            if (arst) chain[g] <= RST_VAL;
            else      chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstgen_debounce.sv
module rstgen_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic arst,
    input  logic din,
    output logic dout
);
    localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          stable;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt    <= '0;
            stable <= 1'b0;
        end else if (din == stable) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            stable <= din;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dout = stable;
endmodule

// File: rtl/rstgen_fsm.sv
module rstgen_fsm
    import rstgen_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic arst,
    input  logic level_req,
    input  logic pulse_trig,
    output logic rst_n_out,
    output logic busy
);
    localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYCLES - 1);

    rs_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          rst_n_q, busy_q;

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state <= RS_HOLD;
            cnt   <= RELOAD;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            RS_IDLE: begin
                if (level_req) begin
                    nxt = RS_HOLD;
                end else if (pulse_trig) begin
                    nxt     = RS_STRETCH;
                    cnt_nxt = RELOAD;
                end
            end
            RS_HOLD: begin
                if (!level_req) begin
                    nxt     = RS_STRETCH;
                    cnt_nxt = RELOAD;
                end
            end
            RS_STRETCH: begin
                if (level_req) begin
                    nxt = RS_HOLD;
                end else if (pulse_trig) begin
                    cnt_nxt = RELOAD;
                end else if (cnt == '0) begin
                    nxt = RS_IDLE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: nxt = RS_HOLD;
        endcase
    end

    // registered outputs: release only on a clock edge
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            rst_n_q <= 1'b0;
            busy_q  <= 1'b1;
        end else begin
            rst_n_q <= (nxt == RS_IDLE);
            busy_q  <= (nxt != RS_IDLE);
        end
    end

    assign rst_n_out = rst_n_q;
    assign busy      = busy_q;
endmodule

// File: rtl/ctl_reset_gen.sv
module ctl_reset_gen #(
    parameter int         PULSE_CYCLES = 8,
    parameter int         DEB_CYCLES   = 16,
    parameter int         SYNC_STAGES  = 2,
    parameter logic [1:0] RST_OFS      = 2'b11
) (
    input  logic       clk,
    input  logic       sys_reset,
    input  logic       card_sel,
    input  logic [1:0] port_ofs,
    input  logic       io_wr_n,
    input  logic       btn_n,
    output logic       ctl_rst_n,
    output logic       rst_busy
);
    logic wr_q;
    logic sw_trig;
    logic btn_sync;
    logic btn_level;

    always_ff @(posedge clk or posedge sys_reset) begin
        if (sys_reset) wr_q <= 1'b1;
        else           wr_q <= io_wr_n;
    end

    assign sw_trig = card_sel && (port_ofs == RST_OFS) && !io_wr_n && wr_q;

    rstgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk  (clk),
        .arst (sys_reset),
        .d    (!btn_n),
        .q    (btn_sync)
    );

    rstgen_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk  (clk),
        .arst (sys_reset),
        .din  (btn_sync),
        .dout (btn_level)
    );

    rstgen_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk        (clk),
        .arst       (sys_reset),
        .level_req  (btn_level),
        .pulse_trig (sw_trig),
        .rst_n_out  (ctl_rst_n),
        .busy       (rst_busy)
    );
endmodule

// File: rtl/ctl_reset_gen_chk.sv
module ctl_reset_gen_chk #(
    parameter int PULSE_CYCLES = 8
) (
    input logic       clk,
    input logic       sys_reset,
    input logic       card_sel,
    input logic [1:0] port_ofs,
    input logic       io_wr_n,
    input logic       ctl_rst_n,
    input logic       btn_level
);
    int low_run;

    always_ff @(posedge clk or posedge sys_reset) begin
        if (sys_reset)       low_run <= 0;
        else if (!ctl_rst_n) low_run <= low_run + 1;
        else                 low_run <= 0;
    end

    AST_SYSRST_LOW: assert property (@(posedge clk) sys_reset |-> !ctl_rst_n); // R2

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (sys_reset)
        $rose(ctl_rst_n) |-> (low_run >= PULSE_CYCLES)); // R4

    AST_SW_TRIGGER: assert property (@(posedge clk) disable iff (sys_reset)
        (card_sel && port_ofs == 2'b11 && !io_wr_n && $past(io_wr_n)) |=> !ctl_rst_n); // R3

    AST_BUTTON_HOLD: assert property (@(posedge clk) disable iff (sys_reset)
        btn_level |=> !ctl_rst_n); // R6

    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (sys_reset)
        $rose(ctl_rst_n) |-> !$past(btn_level)); // R6
endmodule

bind ctl_reset_gen ctl_reset_gen_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .sys_reset (sys_reset),
    .card_sel  (card_sel),
    .port_ofs  (port_ofs),
    .io_wr_n   (io_wr_n),
    .ctl_rst_n (ctl_rst_n),
    .btn_level (btn_level)
);

// File: tb/tb_ctl_reset_gen.sv
module tb_ctl_reset_gen;
    localparam int PULSE = 6;
    localparam int DEB   = 5;

    logic       clk = 1'b0;
    logic       sys_reset = 1'b1;
    logic       card_sel = 1'b0;
    logic [1:0] port_ofs = 2'b00;
    logic       io_wr_n = 1'b1;
    logic       btn_n = 1'b1;
    logic       ctl_rst_n;
    logic       rst_busy;

    always #10 clk = ~clk;

    ctl_reset_gen #(.PULSE_CYCLES(PULSE), .DEB_CYCLES(DEB)) dut (
        .clk(clk), .sys_reset(sys_reset), .card_sel(card_sel), .port_ofs(port_ofs),
        .io_wr_n(io_wr_n), .btn_n(btn_n), .ctl_rst_n(ctl_rst_n), .rst_busy(rst_busy)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";

    task automatic chk(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    int left = 0;
    bit exp_n = 1'b0;
    bit prev_wr = 1'b1;
    bit mstable = 1'b0;
    bit hist[$];

    always @(posedge clk) begin : model
        bit level, trig, flip;
        cyc++;
        if (sys_reset) begin
            hist = {};
            for (int i = 0; i < DEB + 2; i++) hist.push_back(1'b0);
            mstable = 1'b0;
            prev_wr = 1'b1;
            left    = PULSE;
            exp_n   = 1'b0;
        end else begin
            hist.push_front(!btn_n);
            void'(hist.pop_back());
            level = mstable;
            trig  = card_sel && port_ofs == 2'b11 && !io_wr_n && prev_wr;
            flip  = 1'b1;
            for (int i = 2; i <= DEB + 1; i++) if (hist[i] == mstable) flip = 1'b0;
            if (flip) mstable = !mstable;
            prev_wr = io_wr_n;
            if (level)         begin left = PULSE;     exp_n = 1'b0; end
            else if (trig)     begin left = PULSE - 1; exp_n = 1'b0; end
            else if (left > 0) begin left--;           exp_n = 1'b0; end
            else               exp_n = 1'b1;
        end
        #2;
        chk(cur_req, ctl_rst_n, exp_n, "ctl_rst_n vs model");
        chk("R1", rst_busy, !exp_n, "rst_busy vs model");
    end

    // low-width monitor
    int run = 0;
    always @(posedge clk) begin : width_mon
        #3;
        if (sys_reset) run = 0;
        else if (!ctl_rst_n) run++;
        else begin
            if (run > 0) chk("R4", (run >= PULSE) ? 1'b1 : 1'b0, 1'b1, "low period >= PULSE");
            run = 0;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic io_write(logic [1:0] ofs, logic cs, int len);
        @(negedge clk);
        port_ofs = ofs; card_sel = cs; io_wr_n = 1'b0;
        repeat (len) @(negedge clk);
        io_wr_n = 1'b1; card_sel = 1'b0; port_ofs = 2'b00;
    endtask

    task automatic press(int n);
        @(negedge clk); btn_n = 1'b0;
        repeat (n) @(negedge clk);
        btn_n = 1'b1;
    endtask

    initial begin
        idle(3);
        chk("R1", ctl_rst_n, 1'b0, "output during system reset");
        chk("R1", rst_busy, 1'b1, "busy during system reset");
        cur_req = "R2"; sys_reset = 1'b0;
        idle(PULSE + 4);
        chk("R2", ctl_rst_n, 1'b1, "released after stretch");

        cur_req = "R3"; io_write(2'b11, 1'b1, 1); idle(PULSE + 3);
        io_write(2'b00, 1'b1, 1); io_write(2'b01, 1'b1, 1);
        io_write(2'b10, 1'b1, 1); io_write(2'b11, 1'b0, 1);
        idle(4);
        chk("R3", ctl_rst_n, 1'b1, "other offsets / deselected ignored");

        cur_req = "R8"; io_write(2'b11, 1'b1, 5); idle(PULSE + 3);
        cur_req = "R7"; io_write(2'b11, 1'b1, 1); idle(3);
        io_write(2'b11, 1'b1, 1); idle(PULSE + 3);

        cur_req = "R5"; press(DEB - 2); idle(12);
        chk("R5", ctl_rst_n, 1'b1, "short press rejected");
        for (int k = 0; k < 4; k++) begin press(2); idle(2); end
        idle(10);

        cur_req = "R6"; press(15); idle(PULSE + DEB + 6);
        for (int k = 0; k < 3; k++) begin press(1); idle(1); end
        press(12); idle(PULSE + DEB + 6);

        cur_req = "R7"; @(negedge clk); btn_n = 1'b0;
        idle(DEB + 4);
        io_write(2'b11, 1'b1, 1);
        @(negedge clk); btn_n = 1'b1;
        idle(DEB + 3);
        io_write(2'b11, 1'b1, 1);
        idle(PULSE + 4);

        cur_req = "R2";
        @(negedge clk); #3 sys_reset = 1'b1;
        #1 chk("R2", ctl_rst_n, 1'b0, "immediate low on async system reset");
        @(negedge clk); sys_reset = 1'b0;
        idle(PULSE + 4);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule